// File: doc/BRIEF.md
# Double-Threshold List Pruning Unit

This block chooses which candidates survive a branching step of a list decoder. When each of the LIST decoding paths branches on an information bit, 2·LIST candidates appear. Each candidate carries a path metric, the index of its parent path and the bit value it took. The unit returns exactly LIST survivors. It does not sort. It compares every metric against two thresholds that arrive with the request. A lower metric means a more likely path. A metric at or below `thr_keep` is a sure keep. A metric at or above `thr_drop` is a sure drop. A metric strictly between the two is a middle-band candidate. The comparison for each candidate is a single compare against each threshold, so its logic depth does not depend on LIST.

Survivor slots are filled as a stable partition of the candidates. Sure keeps come first in ascending candidate index, then middle-band candidates in ascending index, then sure drops in ascending index. The first LIST entries of that order are the survivors. If there are more than LIST sure keeps, only the lowest-indexed LIST of them are kept and `overflow` is raised with that result.

Control is a two-state machine. In `ST_IDLE` the unit waits for `in_valid`. The transition `ISSUE_DIRECT` is taken when no middle-band candidate exists: the result is registered at once, the state stays in `ST_IDLE`, and `done` rises one cycle after the strobe. The transition `DEFER` is taken when at least one middle-band candidate exists: the request is captured and the machine moves to `ST_HOLD`. From `ST_HOLD` the transition `ISSUE_HELD` always fires on the next edge. It registers the result from the captured request and returns to `ST_IDLE`, so `done` rises two cycles after the strobe.

Top module: `list_pruner`

## Requirements
- R1: Every result holds exactly LIST survivor slots. Each slot carries the parent field and bit value of exactly one candidate, and no candidate fills two slots. Candidate i supplies parent bits `cand_parent[i*PW +: PW]` and bit `cand_bit[i]`. Slot s appears on `surv_parent[s*PW +: PW]` and `surv_bit[s]`.
- R2: When at most LIST candidates have a metric less than or equal to `thr_keep`, every one of them appears among the survivors.
- R3: When more than LIST candidates are sure keeps, the survivors are the LIST sure keeps with the lowest indices and `overflow` is 1 in the cycles where `done` is 1 for that result. In every other cycle `overflow` is 0.
- R4: A candidate whose metric is greater than or equal to `thr_drop`, and that is not a sure keep, never appears while sure-keep plus middle-band candidates number at least LIST.
- R5: The slots after the sure keeps are filled by middle-band candidates (thr_keep < metric < thr_drop) in ascending candidate index.
- R6: When sure-keep plus middle-band candidates are fewer than LIST, the remaining slots take sure-drop candidates in ascending index.
- R7: Slot order is exact: the sure keeps by index, then the middle band by index, then the sure drops by index, truncated to LIST.
- R8: With no middle-band candidate, `done` is 1 in the cycle right after the cycle where `in_valid` was sampled, and the outputs hold the result.
- R9: With at least one middle-band candidate, `done` is 0 in the first cycle after the strobe and 1 in the second.
- R10: After reset, `done`, `overflow`, `surv_parent` and `surv_bit` are all 0.
- R11: When `thr_keep >= thr_drop`, a metric that meets both conditions counts as a sure keep. No middle band then exists, so the result arrives with one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, sampled in `ST_IDLE` |
| cand_metric | input | 2·LIST·MW | Unsigned metric per candidate, slice i at [i*MW +: MW] |
| cand_parent | input | 2·LIST·PW | Parent path index per candidate |
| cand_bit | input | 2·LIST | Bit value per candidate |
| thr_keep | input | MW | Sure-keep threshold (inclusive) |
| thr_drop | input | MW | Sure-drop threshold (inclusive) |
| done | output | 1 | Result valid pulse |
| overflow | output | 1 | More sure keeps than slots in this result |
| surv_parent | output | LIST·PW | Parent index per survivor slot |
| surv_bit | output | LIST | Bit value per survivor slot |

## Verification
The assertions take for granted that `in_valid` is never raised while the machine sits in `ST_HOLD`, and that the thresholds and candidate fields are stable in the cycle the strobe is sampled. The bench drives each request for exactly one cycle and then waits for the full latency before the next one, so no strobe falls into the hold cycle. Candidate tags are set so that parent index and bit together name the candidate index. This lets the bench map every slot back to one candidate and compare it with its own partition order.

// File: rtl/list_pruner_pkg.sv
package list_pruner_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } prune_state_e;

endpackage

// File: rtl/lp_classify.sv
module lp_classify #(
    parameter int NC = 32,
    parameter int MW = 10,
    parameter int CW = 6
) (
    input  logic [NC*MW-1:0] metric,
    input  logic [MW-1:0]    thr_keep,
    input  logic [MW-1:0]    thr_drop,
    output logic [NC-1:0]    is_keep,
    output logic [NC-1:0]    is_mid,
    output logic [CW-1:0]    n_keep,
    output logic [CW-1:0]    n_mid
);

    // One flat compare pair per candidate: depth independent of list size.
    for (genvar i = 0; i < NC; i++) begin : g_cls
        logic [MW-1:0] m;
        assign m          = metric[i*MW +: MW];
        assign is_keep[i] = (m <= thr_keep);
        assign is_mid[i]  = !is_keep[i] && (m < thr_drop);
    end

    always_comb begin
        n_keep = '0;
        n_mid  = '0;
        for (int i = 0; i < NC; i++) begin
            n_keep = n_keep + CW'(is_keep[i]);
            n_mid  = n_mid  + CW'(is_mid[i]);
        end
    end

endmodule

// File: rtl/lp_rank.sv
module lp_rank #(
    parameter int LIST = 16,
    parameter int NC   = 32,
    parameter int PW   = 4,
    parameter int CW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [NC-1:0]     is_keep,
    input  logic [NC-1:0]     is_mid,
    input  logic [CW-1:0]     n_keep,
    input  logic [CW-1:0]     n_mid,
    input  logic [NC*PW-1:0]  cand_parent,
    input  logic [NC-1:0]     cand_bit,
    output logic [LIST*PW-1:0] sel_parent,
    output logic [LIST-1:0]    sel_bit
);

    logic [CW-1:0] rank [NC];
    logic [NC-1:0] hit  [LIST];

    // Stable partition: keep, then middle, then drop, each by index.
    always_comb begin
        logic [CW-1:0] kb, mb, db;
        kb = '0;
        mb = '0;
        db = '0;
        for (int i = 0; i < NC; i++) begin
            if (is_keep[i]) begin
                rank[i] = kb;
                kb      = kb + 1'b1;
            end else if (is_mid[i]) begin
                rank[i] = n_keep + mb;
                mb      = mb + 1'b1;
            end else begin
                rank[i] = n_keep + n_mid + db;
                db      = db + 1'b1;
            end
        end
    end

    always_comb begin
        for (int s = 0; s < LIST; s++) begin
            for (int i = 0; i < NC; i++) begin
                hit[s][i] = (rank[i] == CW'(s));
            end
        end
    end

    always_comb begin
        sel_parent = '0;
        sel_bit    = '0;
        for (int s = 0; s < LIST; s++) begin
            for (int i = 0; i < NC; i++) begin
                if (hit[s][i]) begin
                    sel_parent[s*PW +: PW] = sel_parent[s*PW +: PW] | cand_parent[i*PW +: PW];
                    sel_bit[s]             = sel_bit[s] | cand_bit[i];
                end
            end
        end
    end

    for (genvar s = 0; s < LIST; s++) begin : g_chk
        assert_one_per_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
            chk_en |-> ($countones(hit[s]) == 1))
            else $error("slot %0d not filled by exactly one candidate", s);
    end

endmodule

// File: rtl/list_pruner.sv
module list_pruner
    import list_pruner_pkg::*;
#(
    parameter int LIST = 16,
    parameter int MW   = 10,
    localparam int NC  = 2 * LIST,
    localparam int PW  = $clog2(LIST),
    localparam int CW  = $clog2(NC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [NC*MW-1:0]   cand_metric,
    input  logic [NC*PW-1:0]   cand_parent,
    input  logic [NC-1:0]      cand_bit,
    input  logic [MW-1:0]      thr_keep,
    input  logic [MW-1:0]      thr_drop,
    output logic               done,
    output logic               overflow,
    output logic [LIST*PW-1:0] surv_parent,
    output logic [LIST-1:0]    surv_bit
);

    prune_state_e st, st_nx;

    logic [NC*MW-1:0] h_metric;
    logic [NC*PW-1:0] h_parent;
    logic [NC-1:0]    h_bit;
    logic [MW-1:0]    h_keep, h_drop;

    logic [NC*MW-1:0] s_metric;
    logic [NC*PW-1:0] s_parent;
    logic [NC-1:0]    s_bit;
    logic [MW-1:0]    s_keep, s_drop;

    logic [NC-1:0]    is_keep, is_mid;
    logic [CW-1:0]    n_keep, n_mid;
    logic [LIST*PW-1:0] sel_parent;
    logic [LIST-1:0]    sel_bit;
    logic             accept, issue;

    // One selection network, fed by the live request or the held one.
    assign s_metric = (st == ST_HOLD) ? h_metric : cand_metric;
    assign s_parent = (st == ST_HOLD) ? h_parent : cand_parent;
    assign s_bit    = (st == ST_HOLD) ? h_bit    : cand_bit;
    assign s_keep   = (st == ST_HOLD) ? h_keep   : thr_keep;
    assign s_drop   = (st == ST_HOLD) ? h_drop   : thr_drop;

    lp_classify #(.NC(NC), .MW(MW), .CW(CW)) u_cls (
        .metric   (s_metric),
        .thr_keep (s_keep),
        .thr_drop (s_drop),
        .is_keep  (is_keep),
        .is_mid   (is_mid),
        .n_keep   (n_keep),
        .n_mid    (n_mid)
    );

    lp_rank #(.LIST(LIST), .NC(NC), .PW(PW), .CW(CW)) u_rank (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_en      (issue),
        .is_keep     (is_keep),
        .is_mid      (is_mid),
        .n_keep      (n_keep),
        .n_mid       (n_mid),
        .cand_parent (s_parent),
        .cand_bit    (s_bit),
        .sel_parent  (sel_parent),
        .sel_bit     (sel_bit)
    );

    assign accept = (st == ST_IDLE) && in_valid;

    // Transitions: ISSUE_DIRECT (stay idle), DEFER (to hold), ISSUE_HELD (back).
    always_comb begin
        st_nx = st;
        issue = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (accept && (n_mid == '0)) begin
                    issue = 1'b1;
                end else if (accept) begin
                    st_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                issue = 1'b1;
                st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_metric <= '0;
            h_parent <= '0;
            h_bit    <= '0;
            h_keep   <= '0;
            h_drop   <= '0;
        end else if (accept) begin
            h_metric <= cand_metric;
            h_parent <= cand_parent;
            h_bit    <= cand_bit;
            h_keep   <= thr_keep;
            h_drop   <= thr_drop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            overflow    <= 1'b0;
            surv_parent <= '0;
            surv_bit    <= '0;
        end else begin
            done     <= issue;
            overflow <= issue && (n_keep > CW'(LIST));
            if (issue) begin
                surv_parent <= sel_parent;
                surv_bit    <= sel_bit;
            end
        end
    end

    assert_fast_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && n_mid == '0) |=> done)
        else $error("no middle band but result late");

    assert_slow_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && n_mid != '0) |=> (!done ##1 done))
        else $error("middle band latency wrong");

    assert_flag_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> done)
        else $error("overflow outside a result cycle");

    assert_keep_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && thr_keep >= thr_drop) |=> done)
        else $error("overlapping thresholds did not take the direct path");

    assert_done_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(in_valid, 1) || $past(in_valid, 2)))
        else $error("done without a recent strobe");

endmodule

// File: tb/sim_list_pruner.sv
module sim_list_pruner;

    localparam int CLK_PERIOD = 10;
    localparam int LIST = 16;
    localparam int MW   = 10;
    localparam int NC   = 2 * LIST;
    localparam int PW   = $clog2(LIST);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [NC*MW-1:0]   cand_metric = '0;
    logic [NC*PW-1:0]   cand_parent = '0;
    logic [NC-1:0]      cand_bit = '0;
    logic [MW-1:0]      thr_keep = '0;
    logic [MW-1:0]      thr_drop = '0;
    logic               done;
    logic               overflow;
    logic [LIST*PW-1:0] surv_parent;
    logic [LIST-1:0]    surv_bit;

    int n_tests = 0;
    int n_fail  = 0;

    int met [NC];
    int t1, t2;
    int exp_idx [LIST];
    int exp_nkeep, exp_nmid;

    always #(CLK_PERIOD/2) clk = ~clk;

    list_pruner #(.LIST(LIST), .MW(MW)) u0 (
        .clk, .rst_n, .in_valid, .cand_metric, .cand_parent, .cand_bit,
        .thr_keep, .thr_drop, .done, .overflow, .surv_parent, .surv_bit
    );

    function automatic int cls(input int m);
        if (m <= t1) return 0;
        if (m < t2)  return 1;
        return 2;
    endfunction

    task automatic compute_expected();
        int k = 0;
        exp_nkeep = 0;
        exp_nmid  = 0;
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < NC; i++) begin
                if (cls(met[i]) == c) begin
                    if (k < LIST) exp_idx[k] = i;
                    k++;
                    if (c == 0) exp_nkeep++;
                    if (c == 1) exp_nmid++;
                end
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_case();
        int got [LIST];
        bit d1, d2, seen;
        int bad;
        compute_expected();
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            cand_metric[i*MW +: MW] = MW'(met[i]);
            cand_parent[i*PW +: PW] = PW'(i / 2);
            cand_bit[i]             = 1'(i % 2);
        end
        thr_keep = MW'(t1);
        thr_drop = MW'(t2);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        d1 = done;
        if (exp_nmid == 0) begin
            check(d1 == 1'b1, "R8", "done one cycle after strobe", int'(d1), 1);
        end else begin
            check(d1 == 1'b0, "R9", "done early with middle band", int'(d1), 0);
            @(negedge clk);
            d2 = done;
            check(d2 == 1'b1, "R9", "done two cycles after strobe", int'(d2), 1);
        end
        for (int s = 0; s < LIST; s++)
            got[s] = int'(surv_parent[s*PW +: PW]) * 2 + int'(surv_bit[s]);
        check(overflow == (exp_nkeep > LIST), "R3", "overflow flag",
              int'(overflow), int'(exp_nkeep > LIST));
        bad = -1;
        for (int s = 0; s < LIST; s++)
            if (bad < 0 && got[s] != exp_idx[s]) bad = s;
        check(bad < 0, "R7", "slot order (keep, R5 middle, R6 drop fill)",
              (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : exp_idx[bad]);
        bad = -1;
        for (int a = 0; a < LIST; a++)
            for (int b = a + 1; b < LIST; b++)
                if (got[a] == got[b]) bad = got[a];
        check(bad < 0, "R1", "duplicate survivor candidate", bad, -1);
        if (exp_nkeep <= LIST) begin
            bad = -1;
            for (int i = 0; i < NC; i++) begin
                if (cls(met[i]) == 0) begin
                    seen = 1'b0;
                    for (int s = 0; s < LIST; s++) if (got[s] == i) seen = 1'b1;
                    if (!seen) bad = i;
                end
            end
            check(bad < 0, "R2", "sure keep missing", bad, -1);
        end
        if (exp_nkeep + exp_nmid >= LIST) begin
            bad = -1;
            for (int s = 0; s < LIST; s++) if (cls(met[got[s]]) == 2) bad = got[s];
            check(bad < 0, "R4", "sure drop present", bad, -1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10", "done after reset", int'(done), 0);
        check(overflow == 1'b0, "R10", "overflow after reset", int'(overflow), 0);
        check(surv_parent == '0 && surv_bit == '0, "R10", "survivors after reset",
              int'(surv_bit), 0);
        rst_n = 1'b1;

        // R3: every candidate is a sure keep
        t1 = 600; t2 = 900;
        for (int i = 0; i < NC; i++) met[i] = i * 10;
        run_case();

        // R2: exactly LIST sure keeps, the rest sure drops
        t1 = 100; t2 = 101;
        for (int i = 0; i < NC; i++) met[i] = (i % 2 == 1) ? 50 : 1023;
        run_case();

        // R5: few keeps, plenty of middle band
        t1 = 100; t2 = 800;
        for (int i = 0; i < NC; i++) met[i] = (i % 5 == 0) ? 20 : ((i % 3 == 0) ? 900 : 400);
        run_case();

        // R6: shortfall filled from the drop set
        t1 = 100; t2 = 200;
        for (int i = 0; i < NC; i++) met[i] = (i < 3) ? 150 : ((i > 28) ? 10 : 700);
        run_case();

        // R6: everything dropped
        t1 = 0; t2 = 1;
        for (int i = 0; i < NC; i++) met[i] = 1023 - i;
        run_case();

        // R11: overlapping thresholds
        t1 = 500; t2 = 300;
        for (int i = 0; i < NC; i++) met[i] = 250 + i * 10;
        run_case();

        // Boundaries: metric equal to each threshold, saturated code
        t1 = 300; t2 = 1023;
        for (int i = 0; i < NC; i++) met[i] = (i % 3 == 0) ? 300 : ((i % 3 == 1) ? 1023 : 301);
        run_case();

        for (int n = 0; n < 200; n++) begin
            t1 = int'($urandom % 1024);
            t2 = t1 + int'($urandom % 400);
            if (t2 > 1023) t2 = 1023;
            if (n % 7 == 0) t2 = t1;
            for (int i = 0; i < NC; i++) met[i] = int'($urandom % 1024);
            run_case();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule